// File: doc/BRIEF.md
# Two-wire serial memory target

A target device for a two-wire serial bus (SMBus/I2C style) that serves 256 bytes of storage through an internal 8-bit offset pointer. It samples SCL and SDA with the system clock and spots START, repeated START and STOP conditions. It answers one 7-bit address, formed as a base plus a per-instance index. It drives SDA only through an open-drain enable (`sda_oe` high pulls the line low).

A write transaction always reloads the pointer with its first data byte. Each byte after that is stored at the pointer, which then steps forward and wraps from 255 to 0. A read transaction streams bytes from the pointer, MSB first, for as long as the controller acknowledges. A read has no length byte in front of the data. An address-only transaction in the write direction (a quick command) is acknowledged and changes nothing.

Storage is loaded after reset through a valid/ready preload stream. A word transfers on a clock edge where `pre_valid` and `pre_ready` are both high. `pre_ready` is low from a detected START until the matching STOP. While it is low the producer must hold `pre_valid`, `pre_addr` and `pre_data` steady, and nothing is written.

Top module: `smb_eep_target`

## Requirements
- R1: After reset the pointer is 0, `sda_oe` is low and `pre_ready` is high. A read with no earlier pointer write starts at byte 0.
- R2: An address byte whose upper 7 bits equal 0x50 + DEV_INDEX is acknowledged by pulling SDA low for the ninth clock. Bit 0 of the address byte selects the direction: 1 is read and 0 is write.
- R3: A transaction carrying any other address is ignored. SDA is never driven during it, and neither the pointer nor the storage changes.
- R4: In a write, the first data byte loads the pointer. Each further byte is stored at the pointer, and the pointer then increments.
- R5: The pointer wraps from 255 to 0, both when writing and when reading.
- R6: A read returns the byte at the pointer, MSB first, and the pointer then increments. After the controller NACKs a byte, the target leaves SDA released until a STOP or a repeated START.
- R7: The first byte of a read is the stored data at the pointer. No byte count comes before it.
- R8: A quick command (address with the write bit, then STOP) is acknowledged and leaves the pointer and storage unchanged.
- R9: A repeated START between a pointer write and a read keeps the pointer. A STOP does not reset it either.
- R10: Every data byte received in a write to this target is acknowledged.
- R11: `pre_ready` is low while a bus transaction is active. No preload write happens then. A handshake in idle stores `pre_data` at `pre_addr`.
- R12: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| pre_valid | input | 1 | Preload word valid |
| pre_ready | output | 1 | Preload accepted (bus idle) |
| pre_addr | input | 8 | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
Reads run in several forms:
- straight after reset, which shows that the pointer starts at 0 and that no count byte comes first;
- after a pointer write and a repeated START, which separates pointer retention from a reset to 0;
- after a plain STOP, which shows the pointer carrying across transactions.

Writes that start at 0xFE, and reads that start at 0xFF, cross the wrap point. These fail if the pointer is wider than 8 bits or saturates. A transaction to a neighbouring address, a quick command and a preload held pending during a transaction each attempt a change that must not happen. Read-back afterwards shows whether the pointer or the storage was touched.

// File: rtl/smb_eep_pkg.sv
package smb_eep_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;
  localparam int DEPTH  = 1 << PTR_W;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } bus_state_t;
endpackage

// File: rtl/smb_eep_linesync.sv
module smb_eep_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES:0] scl_p;
  logic [SYNC_STAGES:0] sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_p[SYNC_STAGES-1];
  assign scl_d = scl_p[SYNC_STAGES];
  assign sda_s = sda_p[SYNC_STAGES-1];
  assign sda_d = sda_p[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // line conditions only count while the clock line stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // R12
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise, scl_fall}));
endmodule

// File: rtl/smb_eep_mem.sv
module smb_eep_mem
  import smb_eep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pre_we,
  input  ptr_t  pre_addr,
  input  byte_t pre_data,
  input  logic  bus_we,
  input  ptr_t  bus_addr,
  input  byte_t bus_data,
  input  ptr_t  rd_addr,
  output byte_t rd_data
);
  byte_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (pre_we)      store[pre_addr] <= pre_data;
    else if (bus_we) store[bus_addr] <= bus_data;
  end

  assign rd_data = store[rd_addr];

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_we && bus_we));
endmodule

// File: rtl/smb_eep_ctrl.sv
module smb_eep_ctrl
  import smb_eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scl_s,
  input  logic  sda_s,
  input  logic  scl_rise,
  input  logic  scl_fall,
  input  logic  start_det,
  input  logic  stop_det,
  input  byte_t rd_data,
  output ptr_t  ptr,
  output logic  mem_we,
  output byte_t mem_wdata,
  output logic  sda_oe,
  output logic  busy
);
  bus_state_t state;
  byte_t      shreg;
  cnt_t       bit_cnt;
  logic       rw_bit;
  logic       first_byte;
  logic       host_ack;
  logic       byte_done;

  assign byte_done = (bit_cnt == cnt_t'(BYTE_W));
  assign busy      = (state != ST_IDLE);
  assign mem_wdata = shreg;
  assign mem_we    = (state == ST_WR) && scl_fall && byte_done && !first_byte
                     && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      shreg      <= '0;
      bit_cnt    <= '0;
      rw_bit     <= 1'b0;
      first_byte <= 1'b0;
      host_ack   <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (stop_det) begin
      state      <= ST_IDLE;
      sda_oe     <= 1'b0;
      first_byte <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && byte_done) begin
            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
              rw_bit <= shreg[0];
              sda_oe <= 1'b1;
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_bit) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_RD;
            end else begin
              sda_oe     <= 1'b0;
              first_byte <= 1'b1;
              state      <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && byte_done) begin
            sda_oe <= 1'b1;
            state  <= ST_WR_ACK;
            if (first_byte) begin
              ptr        <= shreg;
              first_byte <= 1'b0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt == cnt_t'(BYTE_W - 1)) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_RD_ACK;
            end else begin
              shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~shreg[BYTE_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              shreg   <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              bit_cnt <= '0;
              state   <= ST_RD;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  // R9
  idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state == ST_IDLE)) |-> $stable(ptr));

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/smb_eep_target.sv
module smb_eep_target
  import smb_eep_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h50,
  parameter int         DEV_INDEX   = 0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       pre_valid,
  output logic       pre_ready,
  input  logic [7:0] pre_addr,
  input  logic [7:0] pre_data
);
  localparam logic [6:0] DEV_ADDR = BASE_ADDR + 7'(DEV_INDEX);

  logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic  bus_we, busy;
  ptr_t  ptr;
  byte_t rd_data, wdata;

  smb_eep_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_eep_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .ptr(ptr), .mem_we(bus_we), .mem_wdata(wdata),
    .sda_oe(sda_oe), .busy(busy)
  );

  assign pre_ready = ~busy;

  smb_eep_mem u_mem (
    .clk(clk), .rst_n(rst_n),
    .pre_we(pre_valid & pre_ready), .pre_addr(pre_addr), .pre_data(pre_data),
    .bus_we(bus_we), .bus_addr(ptr), .bus_data(wdata),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !pre_ready);
endmodule

// File: tb/smb_eep_target_tb.sv
module smb_eep_target_tb;
  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, pre_ready, pre_valid = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;

  int checks = 0, errs = 0;
  int oe_viol = 0, foreign_viol = 0;
  bit foreign = 1'b0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  logic [7:0] mdl_mem [256];
  logic [7:0] mdl_ptr = '0;
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  smb_eep_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pre_valid(pre_valid), .pre_ready(pre_ready), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // line monitors (R12, R3)
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) oe_viol++;
    if (foreign && sda_oe) foreign_viol++;
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", a, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(a == e, t, a, e);
        end
      end
    end
  end

  task automatic bus_bit(input logic b, output logic got);
    m_sda = b;   tick(Q);
    m_scl = 1'b1; tick(Q);
    got = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic g;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], g);
    bus_bit(1'b1, g);
    acked = !g;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, g);
      v[i] = g;
    end
    bus_bit(!ack_it, g);
  endtask

  task automatic wr_txn(input logic [6:0] dev, input int n,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3,
                        input bit exp_ack, input bit do_stop, input string req);
    bit ack;
    logic [7:0] bl [4];
    bl[0] = b0; bl[1] = b1; bl[2] = b2; bl[3] = b3;
    bus_start();
    send_byte({dev, 1'b0}, ack);
    chk(ack == exp_ack, {req, " address ack (R2)"}, ack, exp_ack);
    for (int k = 0; k < n; k++) begin
      send_byte(bl[k], ack);
      chk(ack == exp_ack, {req, " data ack (R10)"}, ack, exp_ack);
      if (exp_ack) begin
        if (k == 0) mdl_ptr = bl[k];
        else begin
          mdl_mem[mdl_ptr] = bl[k];
          mdl_ptr = mdl_ptr + 8'd1;
        end
      end
    end
    if (do_stop) bus_stop();
  endtask

  task automatic rd_txn(input int n, input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, {req, " read address ack (R2)"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mdl_mem[mdl_ptr]);
      tag_q.push_back(req);
      mdl_ptr = mdl_ptr + 8'd1;
      recv_byte(k != n - 1, v);
      act_q.push_back(v);
    end
    tick(2*Q);
    chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ack;
    tick(5);
    chk(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
    chk(pre_ready == 1'b1, "R1 pre_ready at reset", pre_ready, 1);
    rst_n = 1'b1;
    tick(3);

    // preload through the stream, with gaps (R11)
    for (int i = 0; i < 256; i++) begin
      if (i % 16 == 15) begin pre_valid = 1'b0; tick(1); end
      pre_valid = 1'b1;
      pre_addr  = 8'(i);
      pre_data  = 8'(i * 37 + 11);
      mdl_mem[i] = 8'(i * 37 + 11);
      tick(1);
    end
    pre_valid = 1'b0;
    tick(4);

    // R1 / R7: read from reset pointer, first byte is data not a count
    rd_txn(3, "R7 read from pointer 0 (R1)");

    // R4 then R9: pointer write, repeated START, read back
    wr_txn(DEV, 4, 8'h10, 8'hA1, 8'hB2, 8'hC3, 1'b1, 1'b1, "R4 write");
    wr_txn(DEV, 1, 8'h10, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R9 set pointer");
    rd_txn(3, "R9 read after repeated START (R4)");
    // R9: STOP keeps the pointer
    rd_txn(2, "R9 read continues after STOP");

    // R5: wrap on write and read
    wr_txn(DEV, 4, 8'hFE, 8'h5A, 8'h6B, 8'h7C, 1'b1, 1'b1, "R5 write wrap");
    wr_txn(DEV, 1, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R5 set pointer");
    rd_txn(3, "R5 read wrap");

    // R3: foreign address must not disturb pointer or storage
    wr_txn(DEV, 1, 8'h20, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R3 set pointer");
    foreign = 1'b1;
    wr_txn(DEV + 7'd1, 3, 8'h40, 8'hEE, 8'hEE, 8'h00, 1'b0, 1'b1, "R3 foreign");
    foreign = 1'b0;
    chk(foreign_viol == 0, "R3 SDA driven for foreign address", foreign_viol, 0);
    rd_txn(2, "R3 pointer and data kept");
    wr_txn(DEV, 1, 8'h40, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R3 set pointer");
    rd_txn(2, "R3 foreign data not stored");

    // R8: quick command
    wr_txn(DEV, 1, 8'h30, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R8 set pointer");
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R8 quick command ack", ack, 1);
    bus_stop();
    rd_txn(2, "R8 quick command no side effect");

    // R11: preload held off during a transaction
    wr_txn(DEV, 1, 8'h31, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R11 set pointer");
    pre_valid = 1'b1;
    pre_addr  = 8'h31;
    pre_data  = 8'h99;
    tick(2);
    chk(pre_ready == 1'b0, "R11 pre_ready low while busy", pre_ready, 0);
    rd_txn(1, "R11 no preload write while busy");
    while (!pre_ready) tick(1);
    tick(1);
    pre_valid = 1'b0;
    mdl_mem[8'h31] = 8'h99;
    wr_txn(DEV, 1, 8'h31, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R11 set pointer");
    rd_txn(1, "R11 preload after STOP");

    tick(10);
    chk(exp_q.size() == 0, "R6 all expected bytes returned", exp_q.size(), 0);
    chk(oe_viol == 0, "R12 sda_oe changed while SCL high", oe_viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule